// File: doc/BRIEF.md
# Pipelined Sine and Cosine Lookup Generator

This block returns sin(φ), cos(φ), −sin(φ) or −cos(φ) for a 12-bit angle. It has one table that holds the positive half period of the sine function. A 2-bit function select code is added to the two upper angle bits, which moves the phase by a whole number of quarter turns. The lower bits of the shifted angle address the table. The upper bit of the shifted angle then picks whether the value read is passed on or negated. That bit travels through delay registers so that it stays aligned with the registered table read.

The unit is fully pipelined. It accepts one angle on every clock and returns each result a fixed six clocks later, with a valid flag beside it. The table contents are computed at elaboration, so the unit needs no data file. Rotation arithmetic built on the results lies outside this block.

Top module: `trig_lut_gen`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and value_o is 0. Both stay at 0 after reset until the first accepted input has passed through the pipeline.
- R2: An input presented with valid_i high on a rising clock edge produces valid_o high and its result on value_o after the sixth rising edge, counted from that edge inclusive. Inputs may be presented on every clock, and results keep their input order.
- R3: The effective phase p is (angle_i + sel_i·1024) mod 4096. With sel_i = 2'b00 the output is sin, with 2'b01 cos, with 2'b10 −sin and with 2'b11 −cos. Wrap-around beyond 4095 is modulo.
- R4: For p < 2048, value_o equals round(131071·sin(π·p/2048)) as an 18-bit two's complement number, and it is never negative.
- R5: For p ≥ 2048, value_o equals the negation of the R4 value for p − 2048, and it is never positive.
- R6: The following phases give exact results:
  - p = 1024 gives 131071.
  - p = 3072 gives −131071.
  - p = 0 and p = 2048 give 0.
- R7: For an input clock with valid_i low, valid_o is low six clocks later and value_o keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Angle and select are valid this clock |
| angle_i | input | 12 | Angle, full turn = 4096 |
| sel_i | input | 2 | Function select: 00 sin, 01 cos, 10 −sin, 11 −cos |
| valid_o | output | 1 | value_o carries a new result |
| value_o | output | 18 | Signed result, amplitude 131071 |

## Verification
Single points at 0, 1024, 2048 and 3072 under every select code show that the phase offset is added to the right bits and that the negation is taken from the shifted upper bit, not from the raw angle. A back-to-back sweep over the whole circle with an odd step checks every table region against computed values, along with the six-clock timing and the result order. Select codes paired with angles near 4095 catch a missing modulo wrap. Bursts with gaps show that invalid clocks leave the held result untouched.

// File: rtl/trig_lut_pkg.sv
package trig_lut_pkg;

  typedef enum logic [1:0] {
    FN_SIN  = 2'b00,
    FN_COS  = 2'b01,
    FN_NSIN = 2'b10,
    FN_NCOS = 2'b11
  } fn_sel_e;

  localparam real PI_R = 3.14159265358979323846;

  // rounded amp*sin(pi*k/half_len), k in [0, half_len)
  function automatic int sine_word(input int k, input int half_len, input int amp);
    real ang;
    ang = PI_R * real'(k) / real'(half_len);
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/trig_phase_addr.sv
module trig_phase_addr #(
  parameter int ANGLE_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic [1:0]         sel_i,
  output logic               valid_o,
  output logic               half_o,
  output logic [ANGLE_W-2:0] addr_o
);
  localparam int ADDR_W = ANGLE_W - 1;

  logic               cap_valid_q;
  logic [ANGLE_W-1:0] cap_angle_q;
  logic [1:0]         cap_sel_q;
  logic [ANGLE_W-1:0] phase;

  // stage 1: input capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_valid_q <= 1'b0;
      cap_angle_q <= '0;
      cap_sel_q   <= 2'b00;
    end else begin
      cap_valid_q <= valid_i;
      cap_angle_q <= angle_i;
      cap_sel_q   <= sel_i;
    end
  end

  // select code shifts phase in quarter turns, wraps modulo full turn
  always_comb phase = cap_angle_q + {cap_sel_q, {(ANGLE_W-2){1'b0}}};

  // stage 2: split into half select and table address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      half_o  <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= cap_valid_q;
      half_o  <= phase[ANGLE_W-1];
      addr_o  <= phase[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/trig_sine_rom.sv
module trig_sine_rom #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     half_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic                     valid_o,
  output logic                     half_o,
  output logic signed [DATA_W-1:0] data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AMP   = (1 << (DATA_W - 1)) - 1;

  logic signed [DATA_W-1:0] mem [DEPTH];
  logic signed [DATA_W-1:0] rd_q;
  logic                     rd_valid_q;
  logic                     rd_half_q;

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = DATA_W'(trig_lut_pkg::sine_word(k, DEPTH, AMP));
    end
  end

  // stage 3 read and stage 4 output register, data path without reset
  always_ff @(posedge clk_i) begin
    rd_q   <= mem[addr_i];
    data_o <= rd_q;
  end

  // sign bit delayed alongside the two-stage read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_half_q  <= 1'b0;
      valid_o    <= 1'b0;
      half_o     <= 1'b0;
    end else begin
      rd_valid_q <= valid_i;
      rd_half_q  <= half_i;
      valid_o    <= rd_valid_q;
      half_o     <= rd_half_q;
    end
  end

endmodule

// File: rtl/trig_sign_stage.sv
module trig_sign_stage #(
  parameter int DATA_W = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     half_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] value_o
);
  logic                     sgn_valid_q;
  logic signed [DATA_W-1:0] sgn_q;

  // stage 5: conditional negation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sgn_valid_q <= 1'b0;
      sgn_q       <= '0;
    end else begin
      sgn_valid_q <= valid_i;
      sgn_q       <= half_i ? -data_i : data_i;
    end
  end

  // stage 6: output register, holds across invalid clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      value_o <= '0;
    end else begin
      valid_o <= sgn_valid_q;
      if (sgn_valid_q) value_o <= sgn_q;
    end
  end

endmodule

// File: rtl/trig_lut_gen.sv
module trig_lut_gen #(
  parameter int ANGLE_W = 12,
  parameter int DATA_W  = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [ANGLE_W-1:0]       angle_i,
  input  logic [1:0]               sel_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] value_o
);
  localparam int ADDR_W = ANGLE_W - 1;

  logic                     adr_valid;
  logic                     adr_half;
  logic [ADDR_W-1:0]        adr;
  logic                     rom_valid;
  logic                     rom_half;
  logic signed [DATA_W-1:0] rom_data;

  trig_phase_addr #(.ANGLE_W(ANGLE_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .angle_i (angle_i),
    .sel_i   (sel_i),
    .valid_o (adr_valid),
    .half_o  (adr_half),
    .addr_o  (adr)
  );

  trig_sine_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (adr_valid),
    .half_i  (adr_half),
    .addr_i  (adr),
    .valid_o (rom_valid),
    .half_o  (rom_half),
    .data_o  (rom_data)
  );

  trig_sign_stage #(.DATA_W(DATA_W)) u_sign (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rom_valid),
    .half_i  (rom_half),
    .data_i  (rom_data),
    .valid_o (valid_o),
    .value_o (value_o)
  );

endmodule

// File: rtl/trig_lut_gen_chk.sv
module trig_lut_gen_chk #(
  parameter int ANGLE_W = 12,
  parameter int DATA_W  = 18
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic [ANGLE_W-1:0]       angle_i,
  input logic [1:0]               sel_i,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] value_o
);
  localparam int AMP = (1 << (DATA_W - 1)) - 1;
  localparam logic [ANGLE_W-1:0] QTR  = ANGLE_W'(1 << (ANGLE_W - 2));
  localparam logic [ANGLE_W-1:0] TQTR = ANGLE_W'(3 << (ANGLE_W - 2));

  logic [ANGLE_W-1:0] phase_in;
  always_comb phase_in = angle_i + {sel_i, {(ANGLE_W-2){1'b0}}};

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) a_r1_reset_idle: assert (!valid_o && value_o == '0);
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##6 valid_o);

  a_r7_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##6 !valid_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(value_o));

  a_r4_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !phase_in[ANGLE_W-1]) |-> ##6 (value_o >= 0));

  a_r5_nonpos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && phase_in[ANGLE_W-1]) |-> ##6 (value_o <= 0));

  a_r6_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && phase_in == QTR) |-> ##6 (value_o == AMP));

  a_r6_trough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && phase_in == TQTR) |-> ##6 (value_o == -AMP));

endmodule

bind trig_lut_gen trig_lut_gen_chk #(.ANGLE_W(ANGLE_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .angle_i (angle_i),
  .sel_i   (sel_i),
  .valid_o (valid_o),
  .value_o (value_o)
);

// File: tb/trig_lut_gen_tb.sv
module trig_lut_gen_tb;
  localparam int LAT = 6;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic [11:0]        angle_i = '0;
  logic [1:0]         sel_i = 2'b00;
  logic               valid_o;
  logic signed [17:0] value_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit hold_chk = 1'b0;
  int last_val = 0;

  int    q_val[$];
  int    q_cyc[$];
  string q_tag[$];

  trig_lut_gen u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .angle_i (angle_i),
    .sel_i   (sel_i),
    .valid_o (valid_o),
    .value_o (value_o)
  );

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int expect_val(input int ang, input int sel);
    int p, k, v;
    p = (ang + sel * 1024) % 4096;
    k = p % 2048;
    v = $rtoi(131071.0 * $sin(3.14159265358979323846 * real'(k) / 2048.0) + 0.5);
    return (p >= 2048) ? -v : v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int ang, input int sel, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1;
    angle_i = 12'(ang);
    sel_i   = 2'(sel);
    q_val.push_back(expect_val(ang, sel));
    q_cyc.push_back(cyc + LAT);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      angle_i = 12'hABC;
      sel_i   = 2'b11;
    end
  endtask

  task automatic drain();
    idle(1);
    while (q_val.size() != 0) @(negedge clk_i);
  endtask

  // scoreboard: value and exact arrival cycle (R2)
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (q_val.size() == 0) begin
          check("R2 unexpected valid_o", 1, 0);
        end else begin
          int ev, ec;
          string tg;
          ev = q_val.pop_front();
          ec = q_cyc.pop_front();
          tg = q_tag.pop_front();
          check({tg, " value"}, int'(value_o), ev);
          check({tg, " R2 cycle"}, cyc, ec);
        end
        last_val = int'(value_o);
      end else if (hold_chk) begin
        check("R7 hold", int'(value_o), last_val);
      end
    end
  end

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check("R1 valid_o in reset", int'(valid_o), 0);
    check("R1 value_o in reset", int'(value_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 valid_o after reset", int'(valid_o), 0);
    check("R1 value_o after reset", int'(value_o), 0);
  endtask

  task automatic t_exact_points();
    drive(0,    0, "R6 sin0");
    drive(1024, 0, "R6 sin1024");
    drive(2048, 0, "R6 sin2048");
    drive(3072, 0, "R6 sin3072");
    drive(0,    1, "R3 cos0");
    drive(2048, 1, "R3 cos2048");
    drive(1024, 2, "R3 nsin1024");
    drive(0,    3, "R3 ncos0");
    drain();
  endtask

  task automatic t_sweep();
    for (int a = 3; a < 4096; a += 37) drive(a, 0, "R4 R5 sweep");
    drive(2047, 0, "R4 last_pos");
    drive(2049, 0, "R5 first_neg");
    drain();
  endtask

  task automatic t_selectors();
    for (int s = 0; s < 4; s++) begin
      drive(100,  s, "R3 sel_a100");
      drive(1500, s, "R3 sel_a1500");
      drive(3333, s, "R3 sel_a3333");
    end
    drain();
  endtask

  task automatic t_wrap();
    drive(4095, 1, "R3 wrap_cos4095");
    drive(3500, 2, "R3 wrap_nsin3500");
    drive(3072, 3, "R3 wrap_ncos3072");
    drive(4000, 3, "R3 wrap_ncos4000");
    drain();
  endtask

  task automatic t_bubbles();
    hold_chk = 1'b1;
    drive(512, 0, "R7 burst");
    idle(3);
    drive(2600, 0, "R7 burst");
    drive(700,  1, "R7 burst");
    idle(2);
    drive(3900, 2, "R7 burst");
    drain();
    repeat (4) @(negedge clk_i);
    hold_chk = 1'b0;
  endtask

  initial begin
    t_reset();
    t_exact_points();
    t_sweep();
    t_selectors();
    t_wrap();
    t_bubbles();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule